// File: doc/BRIEF.md
# Receive FIFO Acceptance Filter Table

This block decides whether a received CAN frame is admitted to a receive FIFO. Each frame is described by its identifier, an extended-format flag and a remote-request flag, and it arrives with a one-cycle valid strobe. The block compares the frame against a table of filter words, each paired with its own mask word. It reports whether the frame is accepted and which filter entry matched, on a one-cycle result strobe.

The same table storage can be read in three ways, chosen by a format input. It can hold full extended-identifier filters with one per word, standard-identifier filters with two per word, or 8-bit identifier-slice filters with four per word. Every sub-entry has its own mask. Where the format has flag fields, the mask covers them as well as the identifier. Filter and mask words are loaded through a simple word-wide write port. Mailbox matching elsewhere sees the same frame in parallel, and this block does not block it.

Top module: `rx_fifo_filter`

## Requirements
- R1: After reset, res_valid_o, res_accept_o and res_hit_o are all zero, and they stay zero until a frame strobe has been seen.
- R2: A frame strobed with frm_valid_i in cycle n produces res_valid_o high for exactly cycle n+2. Back-to-back strobes give back-to-back results, in order.
- R3: In format 0 (extended), entry e occupies word e: bit 31 = RTR, bit 30 = IDE, bit 29 = unused, bits 28:0 = identifier. The received key has the same layout, with bit 29 = 0. Entry e matches when (filter ^ key) & mask == 0. The hit index is e, so it is below the entry count.
- R4: In format 1 (standard pair), word e holds sub-entry 2e in bits 31:16 and sub-entry 2e+1 in bits 15:0. Each half is laid out as RTR at bit 15, IDE at bit 14, three unused bits, and an 11-bit identifier at bits 10:0. A standard frame compares identifier bits 10:0. An extended frame compares identifier bits 28:18.
- R5: In format 2 (slice), word e holds sub-entries 4e..4e+3, from bits 31:24 down to bits 7:0. Each slice is compared under its 8-bit mask with the top 8 identifier bits. These are bits 10:3 for a standard frame and bits 28:21 for an extended frame.
- R6: A mask bit of 1 forces the matching filter bit to equal the received bit. A mask bit of 0 makes that bit don't-care. This applies to the identifier, IDE and RTR fields alike.
- R7: When several sub-entries match, the hit index is that of the lowest-numbered one.
- R8: When fifo_en_i is low in the strobe cycle, res_accept_o is low for that frame and res_hit_o is zero. res_valid_o still pulses.
- R9: res_hit_o is zero whenever res_accept_o is low. res_accept_o is high only together with res_valid_o. Format value 3 accepts no frame.
- R10: A write with cfg_we_i high stores cfg_wdata_i into the filter word (cfg_sel_i = 0) or the mask word (cfg_sel_i = 1) of entry cfg_addr_i, and changes no other word. A write made before the strobe cycle applies to that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO filtering enabled |
| fmt_i | input | 2 | Table format: 0 extended, 1 standard pair, 2 slice, 3 none |
| cfg_we_i | input | 1 | Table write enable |
| cfg_sel_i | input | 1 | 0 selects filter word, 1 selects mask word |
| cfg_addr_i | input | 3 | Entry index for the write |
| cfg_wdata_i | input | 32 | Write data |
| frm_valid_i | input | 1 | Received frame strobe |
| frm_id_i | input | 29 | Received identifier (standard frames use bits 10:0) |
| frm_ide_i | input | 1 | Received frame uses extended identifier |
| frm_rtr_i | input | 1 | Received frame is a remote request |
| res_valid_o | output | 1 | Result strobe |
| res_accept_o | output | 1 | Frame accepted into FIFO |
| res_hit_o | output | 5 | Index of the matching sub-entry |

## Verification
The assertions assume that fmt_i and fifo_en_i are meaningful only in the strobe cycle, and they relate results to the values those inputs had two cycles earlier. The bench changes format, enable and table contents only between frames, so the sampled values always belong to the frame being judged. The assertions also assume the frame fields are stable during the strobe. The bench sets every field at the same falling edge as the strobe and holds them until the next falling edge.

// File: rtl/rxff_pkg.sv
package rxff_pkg;
  typedef enum logic [1:0] {
    FMT_EXT   = 2'd0,
    FMT_STD   = 2'd1,
    FMT_SLICE = 2'd2,
    FMT_NONE  = 2'd3
  } rxff_fmt_e;

  localparam int unsigned ID_W   = 29;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
  } rxff_frame_t;
endpackage

// File: rtl/rxff_table.sv
module rxff_table
  import rxff_pkg::*;
#(
  parameter  int unsigned NUM_ENT = 8,
  localparam int unsigned AW      = $clog2(NUM_ENT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic                           sel_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  output logic [NUM_ENT-1:0][WORD_W-1:0] flt_o,
  output logic [NUM_ENT-1:0][WORD_W-1:0] msk_o
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic hit_addr;
    assign hit_addr = we_i && (addr_i == AW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flt_o[e] <= '0;
        msk_o[e] <= '0;
      end else if (hit_addr) begin
        if (sel_i) msk_o[e] <= wdata_i;
        else       flt_o[e] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/rxff_match.sv
module rxff_match
  import rxff_pkg::*;
#(
  parameter  int unsigned NUM_ENT = 8,
  localparam int unsigned NUM_SUB = 4 * NUM_ENT
) (
  input  rxff_frame_t                    frame_i,
  input  rxff_fmt_e                      fmt_i,
  input  logic [NUM_ENT-1:0][WORD_W-1:0] flt_i,
  input  logic [NUM_ENT-1:0][WORD_W-1:0] msk_i,
  output logic [NUM_SUB-1:0]             hit_vec_o
);
  logic [10:0]          std_id;
  logic [WORD_W-1:0]    key_ext;
  logic [15:0]          key_std;
  logic [7:0]           key_slc;
  logic [NUM_ENT-1:0]   m_ext;
  logic [2*NUM_ENT-1:0] m_std;
  logic [NUM_SUB-1:0]   m_slc;

  // extended frames present their top 11 identifier bits to standard filters
  assign std_id  = frame_i.ide ? frame_i.id[28:18] : frame_i.id[10:0];
  assign key_ext = {frame_i.rtr, frame_i.ide, 1'b0, frame_i.id};
  assign key_std = {frame_i.rtr, frame_i.ide, 3'b000, std_id};
  assign key_slc = frame_i.ide ? frame_i.id[28:21] : frame_i.id[10:3];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign m_ext[e] = ((flt_i[e] ^ key_ext) & msk_i[e]) == '0;

    for (genvar s = 0; s < 2; s++) begin : g_std
      localparam int unsigned HI = 31 - 16 * s;
      assign m_std[2*e+s] = ((flt_i[e][HI -: 16] ^ key_std) & msk_i[e][HI -: 16]) == '0;
    end

    for (genvar s = 0; s < 4; s++) begin : g_slc
      localparam int unsigned HI = 31 - 8 * s;
      assign m_slc[4*e+s] = ((flt_i[e][HI -: 8] ^ key_slc) & msk_i[e][HI -: 8]) == '0;
    end
  end

  always_comb begin
    unique case (fmt_i)
      FMT_EXT:   hit_vec_o = NUM_SUB'(m_ext);
      FMT_STD:   hit_vec_o = NUM_SUB'(m_std);
      FMT_SLICE: hit_vec_o = m_slc;
      default:   hit_vec_o = '0;
    endcase
  end
endmodule

// File: rtl/rxff_prio.sv
module rxff_prio #(
  parameter  int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rx_fifo_filter.sv
module rx_fifo_filter
  import rxff_pkg::*;
#(
  parameter  int unsigned NUM_ENT = 8,
  localparam int unsigned AW      = $clog2(NUM_ENT),
  localparam int unsigned NUM_SUB = 4 * NUM_ENT,
  localparam int unsigned IDX_W   = $clog2(NUM_SUB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic [1:0]        fmt_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              frm_ide_i,
  input  logic              frm_rtr_i,
  output logic              res_valid_o,
  output logic              res_accept_o,
  output logic [IDX_W-1:0]  res_hit_o
);
  logic [NUM_ENT-1:0][WORD_W-1:0] flt;
  logic [NUM_ENT-1:0][WORD_W-1:0] msk;

  logic        s1_vld_q;
  logic        s1_en_q;
  rxff_fmt_e   s1_fmt_q;
  rxff_frame_t s1_frm_q;

  logic [NUM_SUB-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               accept_d;

  rxff_table #(.NUM_ENT(NUM_ENT)) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .flt_o   (flt),
    .msk_o   (msk)
  );

  // stage 1: capture frame with the format and enable in force at its strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_en_q  <= 1'b0;
      s1_fmt_q <= FMT_NONE;
      s1_frm_q <= '0;
    end else begin
      s1_vld_q <= frm_valid_i;
      if (frm_valid_i) begin
        s1_en_q  <= fifo_en_i;
        s1_fmt_q <= rxff_fmt_e'(fmt_i);
        s1_frm_q <= '{id: frm_id_i, ide: frm_ide_i, rtr: frm_rtr_i};
      end
    end
  end

  rxff_match #(.NUM_ENT(NUM_ENT)) i_match (
    .frame_i   (s1_frm_q),
    .fmt_i     (s1_fmt_q),
    .flt_i     (flt),
    .msk_i     (msk),
    .hit_vec_o (hit_vec)
  );

  rxff_prio #(.WIDTH(NUM_SUB)) i_prio (
    .req_i (hit_vec),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  assign accept_d = s1_vld_q && s1_en_q && any_hit;

  // stage 2: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_accept_o <= 1'b0;
      res_hit_o    <= '0;
    end else begin
      res_valid_o  <= s1_vld_q;
      res_accept_o <= accept_d;
      res_hit_o    <= accept_d ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/rx_fifo_filter_chk.sv
module rx_fifo_filter_chk
  import rxff_pkg::*;
#(
  parameter  int unsigned NUM_ENT = 8,
  localparam int unsigned AW      = $clog2(NUM_ENT),
  localparam int unsigned NUM_SUB = 4 * NUM_ENT,
  localparam int unsigned IDX_W   = $clog2(NUM_SUB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic [1:0]        fmt_i,
  input logic              cfg_we_i,
  input logic              cfg_sel_i,
  input logic [AW-1:0]     cfg_addr_i,
  input logic [WORD_W-1:0] cfg_wdata_i,
  input logic              frm_valid_i,
  input logic [ID_W-1:0]   frm_id_i,
  input logic              frm_ide_i,
  input logic              frm_rtr_i,
  input logic              res_valid_o,
  input logic              res_accept_o,
  input logic [IDX_W-1:0]  res_hit_o
);
  logic [1:0] cyc_q;

  // cycles since reset, saturating, so $past never reaches into reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> ##1 res_valid_o); // R2

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !$past(frm_valid_i, 2)) |-> !res_valid_o); // R2

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_accept_o |-> res_valid_o); // R9

  AST_HIT_ZERO_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_accept_o |-> (res_hit_o == '0)); // R9

  AST_RESERVED_FMT_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && res_valid_o && $past(fmt_i, 2) == 2'd3) |-> !res_accept_o); // R9

  AST_DISABLED_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && res_valid_o && !$past(fifo_en_i, 2)) |-> !res_accept_o); // R8

  AST_EXT_HIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && res_accept_o && $past(fmt_i, 2) == 2'd0) |-> (res_hit_o < IDX_W'(NUM_ENT))); // R3

  AST_STD_HIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && res_accept_o && $past(fmt_i, 2) == 2'd1) |-> (res_hit_o < IDX_W'(2 * NUM_ENT))); // R4
endmodule

bind rx_fifo_filter rx_fifo_filter_chk #(.NUM_ENT(NUM_ENT)) i_chk (.*);

// File: tb/test_rx_fifo_filter.sv
module test_rx_fifo_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        fv = 1'b0;
  logic [28:0] fid = '0;
  logic        fide = 1'b0;
  logic        frtr = 1'b0;
  logic        rv;
  logic        ra;
  logic [4:0]  rh;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] flt_m [8];
  logic [31:0] msk_m [8];

  always #2.5ns clk = ~clk;

  rx_fifo_filter i_rx_fifo_filter (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(en), .fmt_i(fmt),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .frm_valid_i(fv), .frm_id_i(fid), .frm_ide_i(fide), .frm_rtr_i(frtr),
    .res_valid_o(rv), .res_accept_o(ra), .res_hit_o(rh)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; addr = 3'(a); wdata = d;
    if (s) msk_m[a] = d; else flt_m[a] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // expected result from the requirements: {accept, hit[4:0]}
  function automatic logic [5:0] model(input logic [1:0] f, input logic e,
                                       input logic [28:0] id, input logic ide, input logic rtr);
    logic [31:0] kx;
    logic [15:0] ks;
    logic [7:0]  kb;
    kx = {rtr, ide, 1'b0, id};
    ks = {rtr, ide, 3'b000, (ide ? id[28:18] : id[10:0])};
    kb = ide ? id[28:21] : id[10:3];
    if (!e) return 6'd0;
    case (f)
      2'd0: for (int i = 0; i < 8; i++)
              if (((flt_m[i] ^ kx) & msk_m[i]) == 0) return {1'b1, 5'(i)};
      2'd1: for (int i = 0; i < 16; i++) begin
              logic [15:0] fh, mh;
              fh = 16'(flt_m[i/2] >> (16 * (1 - i % 2)));
              mh = 16'(msk_m[i/2] >> (16 * (1 - i % 2)));
              if (((fh ^ ks) & mh) == 0) return {1'b1, 5'(i)};
            end
      2'd2: for (int i = 0; i < 32; i++) begin
              logic [7:0] fb, mb;
              fb = 8'(flt_m[i/4] >> (8 * (3 - i % 4)));
              mb = 8'(msk_m[i/4] >> (8 * (3 - i % 4)));
              if (((fb ^ kb) & mb) == 0) return {1'b1, 5'(i)};
            end
      default: ;
    endcase
    return 6'd0;
  endfunction

  task automatic frame(input logic [28:0] id, input logic ide, input logic rtr, input string req);
    logic [5:0] exp;
    exp = model(fmt, en, id, ide, rtr);
    @(negedge clk);
    fv = 1'b1; fid = id; fide = ide; frtr = rtr;
    @(negedge clk);
    fv = 1'b0;
    @(negedge clk);
    chk(rv === 1'b1, req, int'(rv), 1);
    chk({ra, rh} === exp, req, int'({ra, rh}), int'(exp));
  endtask

  initial begin
    #900us;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] e0, e1, e2;
    for (int i = 0; i < 8; i++) begin flt_m[i] = '0; msk_m[i] = '0; end
    repeat (3) @(negedge clk);
    chk({rv, ra, rh} === 7'd0, "R1 reset", int'({rv, ra, rh}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({rv, ra, rh} === 7'd0, "R1 idle", int'({rv, ra, rh}), 0);
    en = 1'b1;

    // R3 / R6 directed extended matches
    fmt = 2'd0;
    for (int i = 0; i < 8; i++) begin wr(0, i, 32'h2000_0000); wr(1, i, 32'hFFFF_FFFF); end
    wr(0, 0, {1'b0, 1'b1, 1'b0, 29'h1ABC_DE01});
    frame(29'h1ABC_DE01, 1'b1, 1'b0, "R3 exact");
    frame(29'h1ABC_DE01, 1'b1, 1'b1, "R3 rtr differs");
    frame(29'h1ABC_DE01, 1'b0, 1'b0, "R3 ide differs");
    wr(1, 0, 32'h7FFF_FFF0);
    frame(29'h1ABC_DE0F, 1'b1, 1'b1, "R6 rtr and low bits dont care");

    // R7: all masks zero, every entry matches
    for (int i = 0; i < 8; i++) wr(1, i, 32'h0);
    frame(29'h0123_4567, 1'b1, 1'b0, "R7 lowest wins ext");

    // R10: only entry 5 reachable, write affects only its word
    for (int i = 0; i < 8; i++) wr(1, i, 32'hFFFF_FFFF);
    wr(0, 5, {1'b0, 1'b1, 1'b0, 29'h0055_5555});
    frame(29'h0055_5555, 1'b1, 1'b0, "R10 entry 5 write");
    chk(rh === 5'd5, "R10 hit index", int'(rh), 5);

    // R3 sweep: nested ranges create overlaps
    for (int i = 0; i < 8; i++) begin
      wr(0, i, {1'b0, 1'b1, 1'b0, 29'h0100_0000 + 29'(i * 64)});
      wr(1, i, {3'b110, 29'h1FFF_FFFF << i} | (i == 7 ? 32'h0 : 32'h8000_0000));
    end
    for (int j = 0; j < 600; j++) frame(29'h0100_0000 + 29'(j), 1'b1, 1'(j % 3 == 0), "R3 R7 sweep");

    // R4 sweep over all standard identifiers
    fmt = 2'd1;
    for (int e = 0; e < 8; e++) begin
      logic [15:0] h0, h1, m0, m1;
      h0 = {5'b00000, 11'((2 * e) * 128)};
      h1 = {5'b00000, 11'((2 * e + 1) * 128 + 64)};
      m0 = {2'b11, 3'b000, 11'h7FF << (e % 8)};
      m1 = {2'b01, 3'b000, 11'h7FF << ((e + 3) % 8)};
      wr(0, e, {h0, h1});
      wr(1, e, {m0, m1});
    end
    for (int j = 0; j < 2048; j++) frame(29'(j), 1'b0, 1'(j % 5 == 0), "R4 std sweep");
    for (int j = 0; j < 64; j++) frame(29'(j) << 22, 1'b1, 1'b0, "R4 ext frame in std");

    // R5 sweep over all slice values, both frame types
    fmt = 2'd2;
    for (int e = 0; e < 8; e++) begin
      wr(0, e, {8'(e * 32), 8'(e * 32 + 8), 8'(e * 32 + 16), 8'(e * 32 + 24)});
      wr(1, e, (e % 2 == 0) ? 32'hF8F0_FFE0 : 32'hFFFF_F8FC);
    end
    for (int v = 0; v < 256; v++) begin
      frame({18'h0, 8'(v), 3'b101}, 1'b0, 1'b0, "R5 slice std");
      frame({8'(v), 21'h0A5A5}, 1'b1, 1'b1, "R5 slice ext");
    end

    // R8 disabled
    en = 1'b0;
    frame({18'h0, 8'd0, 3'b000}, 1'b0, 1'b0, "R8 disabled");
    frame({18'h0, 8'd9, 3'b000}, 1'b0, 1'b0, "R8 disabled");
    en = 1'b1;

    // R9 reserved format with masks zero
    for (int i = 0; i < 8; i++) wr(1, i, 32'h0);
    fmt = 2'd3;
    frame(29'h0, 1'b0, 1'b0, "R9 reserved format");
    frame(29'h1FFF_FFFF, 1'b1, 1'b1, "R9 reserved format");

    // R2 back-to-back frames in extended format
    fmt = 2'd0;
    wr(1, 0, 32'hFFFF_FFFF);
    wr(0, 0, {3'b010, 29'h0000_0AAA});
    e0 = model(2'd0, 1'b1, 29'h0000_0AAA, 1'b1, 1'b0);
    e1 = model(2'd0, 1'b1, 29'h0000_0BBB, 1'b1, 1'b0);
    e2 = model(2'd0, 1'b1, 29'h0000_0AAA, 1'b1, 1'b1);
    @(negedge clk); fv = 1'b1; fid = 29'h0000_0AAA; fide = 1'b1; frtr = 1'b0;
    @(negedge clk);
    chk(rv === 1'b0, "R2 not early", int'(rv), 0);
    fid = 29'h0000_0BBB;
    @(negedge clk);
    chk({rv, ra, rh} === {1'b1, e0}, "R2 first", int'({rv, ra, rh}), int'({1'b1, e0}));
    fid = 29'h0000_0AAA; frtr = 1'b1;
    @(negedge clk);
    fv = 1'b0;
    chk({rv, ra, rh} === {1'b1, e1}, "R2 second", int'({rv, ra, rh}), int'({1'b1, e1}));
    @(negedge clk);
    chk({rv, ra, rh} === {1'b1, e2}, "R2 third", int'({rv, ra, rh}), int'({1'b1, e2}));
    @(negedge clk);
    chk(rv === 1'b0, "R2 single pulse", int'(rv), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule